// File: doc/BRIEF.md
# DRAM Power-Up and ZQ Calibration Sequencer

This block sits in the command path of a DDR memory controller. It takes the device from power-up to a usable state. First it holds the DRAM reset pin low. Then it releases reset while clock-enable stays low, and after that it raises clock-enable. Next it writes the seven mode registers in a fixed reverse order, with the spacing the device needs between writes. A long impedance calibration follows, and the block then waits out the DLL lock time before it reports that the device is ready.

In normal operation it runs two kinds of calibration on request. A periodic request starts a short calibration that tracks voltage and temperature drift. A self-refresh-exit request starts a long calibration, which is shorter than the first one after reset. While any sequence or calibration window is open, `busy` stays high, so the command arbiter must hold back user traffic. A request that arrives while a window is open is remembered. It is issued in the first cycle after that window closes.

All intervals are parameters counted in controller clock cycles. The command bus drives an idle encoding in every cycle that carries no command.

Top module: `dram_init_zq_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until `start` is sampled high, the outputs are `dram_reset_n`=0, `cke`=0, `cmd`=0 (idle), `addr`=0, `bank`=0, `busy`=1 and `ready`=0.
- R2: Take cycle 0 as the cycle after the edge that samples `start`. `dram_reset_n` stays low for T_RST cycles and then stays high. `cke` stays low for T_CKE more cycles and is high from cycle T_RST+T_CKE on.
- R3: Seven mode-register writes (`cmd`=1) are issued. The first is in cycle T_RST+T_CKE, and each later one follows the previous one by exactly T_MRD cycles. `bank` carries the register number in the order 3, 6, 5, 4, 2, 1, 0. `addr` carries slice [n*ADDR_W +: ADDR_W] of `mr_values` for register n.
- R4: The power-up long calibration (`cmd`=2, only `addr` bit ZQ_LONG_BIT set, `bank`=0) is issued exactly T_MOD cycles after the last mode-register write.
- R5: `ready` rises exactly T_ZQINIT+T_DLLK cycles after the power-up long calibration command. `busy` is high and `ready` is low in every cycle before that.
- R6: When `zqcs_req` is sampled high while the block is ready, a short calibration (`cmd`=3, `addr`=0) is issued in the next cycle. `busy` then stays high for T_ZQCS cycles, counted from the command.
- R7: When `sr_exit` is sampled high while the block is ready, a long calibration (`cmd`=2, `addr` bit ZQ_LONG_BIT set) is issued in the next cycle. `busy` stays high for T_ZQOPER cycles, counted from the command, and no DLL wait follows.
- R8: A `zqcs_req` sampled while `busy` is high is kept pending. The short calibration is issued in the first cycle after the running window or power-up sequence ends, with no ready cycle in between.
- R9: If a long and a short calibration are both due at the same time, the long one is issued first and the short one directly after it.
- R10: Every cycle that carries no command drives `cmd`=0, `addr`=0 and `bank`=0.
- R11: `start` has no effect once the power-up sequence has begun or completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the power-up sequence |
| zqcs_req | input | 1 | Periodic short calibration request |
| sr_exit | input | 1 | Self-refresh has ended; a long calibration is required |
| mr_values | input | 7*ADDR_W | Mode-register contents, register n in slice n |
| dram_reset_n | output | 1 | DRAM reset pin, active low |
| cke | output | 1 | DRAM clock enable |
| cmd | output | 2 | Command code: 0 idle, 1 mode-register write, 2 long calibration, 3 short calibration |
| addr | output | ADDR_W | Address bus for the command |
| bank | output | BANK_W | Bank bus; carries the register number during a mode-register write |
| busy | output | 1 | High when user commands must be blocked |
| ready | output | 1 | Device initialised and no calibration running |

## Verification
Each result is due a fixed number of cycles after the edge that samples its stimulus. The power-up steps fall at sums of the interval parameters, measured from the edge that samples `start`. A calibration command appears one cycle after the edge that samples its request. `ready` returns exactly one window length after that command. The bench uses small interval values and computes the expected contents of every output in every cycle of each window. It samples on the falling clock edge and changes inputs only there. This gives a cycle-exact comparison over the whole power-up and over each calibration scenario.

// File: rtl/dzq_pkg.sv
package dzq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_MRS = 2'd1,
    CMD_ZQL = 2'd2,
    CMD_ZQS = 2'd3
  } dzq_cmd_e;

  typedef enum logic [3:0] {
    S_OFF  = 4'd0,
    S_RST  = 4'd1,
    S_CKE  = 4'd2,
    S_MRS  = 4'd3,
    S_MRSW = 4'd4,
    S_ZQL  = 4'd5,
    S_ZQLW = 4'd6,
    S_DLL  = 4'd7,
    S_IDLE = 4'd8,
    S_ZQS  = 4'd9,
    S_ZQSW = 4'd10
  } dzq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dzq_wait_timer.sv
module dzq_wait_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dzq_mr_order.sv
module dzq_mr_order #(
  parameter int ADDR_W = 14,
  parameter int MR_NUM = 7
) (
  input  logic [2:0]             step,
  input  logic [MR_NUM*ADDR_W-1:0] mr_values,
  output logic [2:0]             mr_id,
  output logic [ADDR_W-1:0]      mr_word
);

  logic [ADDR_W-1:0] words [MR_NUM];

  for (genvar g = 0; g < MR_NUM; g++) begin : g_slice
    assign words[g] = mr_values[g*ADDR_W +: ADDR_W];
  end

  // step 0 writes register 3; steps 1..3 count 6 down to 4; steps 4..6 count 2 down to 0
  always_comb begin
    if (step == 3'd0)       mr_id = 3'd3;
    else if (step <= 3'd3)  mr_id = 3'd7 - step;
    else                    mr_id = 3'd6 - step;
  end

  assign mr_word = words[mr_id];

endmodule

// File: rtl/dram_init_zq_seq.sv
module dram_init_zq_seq
  import dzq_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BANK_W      = 3,
  parameter int ZQ_LONG_BIT = 10,
  parameter int T_RST       = 200,
  parameter int T_CKE       = 50,
  parameter int T_MRD       = 8,
  parameter int T_MOD       = 24,
  parameter int T_ZQINIT    = 512,
  parameter int T_ZQOPER    = 256,
  parameter int T_ZQCS      = 64,
  parameter int T_DLLK      = 597
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                zqcs_req,
  input  logic                sr_exit,
  input  logic [7*ADDR_W-1:0] mr_values,
  output logic                dram_reset_n,
  output logic                cke,
  output logic [1:0]          cmd,
  output logic [ADDR_W-1:0]   addr,
  output logic [BANK_W-1:0]   bank,
  output logic                busy,
  output logic                ready
);

  localparam int MR_NUM = 7;
  localparam int T_MAX  = max2(max2(max2(T_RST, T_CKE), max2(T_MRD, T_MOD)),
                               max2(max2(T_ZQINIT, T_ZQOPER), max2(T_ZQCS, T_DLLK)));
  localparam int CNT_W  = $clog2(T_MAX + 1);

  dzq_state_e        st_q, nxt;
  logic [2:0]        step_q, step_d;
  logic              boot_q, boot_d;
  logic              zqs_pend_q, zqs_pend_d;
  logic              srx_pend_q, srx_pend_d;
  logic              tmr_done, tmr_load;
  logic [CNT_W-1:0]  ld_val;
  logic              last_mr, zqs_any, srx_any;
  dzq_state_e        disp;
  logic [2:0]        mr_id;
  logic [ADDR_W-1:0] mr_word;

  dzq_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (ld_val),
    .done     (tmr_done)
  );

  dzq_mr_order #(.ADDR_W(ADDR_W), .MR_NUM(MR_NUM)) u_order (
    .step      (step_q),
    .mr_values (mr_values),
    .mr_id     (mr_id),
    .mr_word   (mr_word)
  );

  assign last_mr = (step_q == 3'(MR_NUM - 1));
  assign zqs_any = zqs_pend_q | zqcs_req;
  assign srx_any = srx_pend_q | sr_exit;
  // long calibration wins over short when both are due
  assign disp    = srx_any ? S_ZQL : (zqs_any ? S_ZQS : S_IDLE);

  // next-state decision
  always_comb begin
    nxt = st_q;
    unique case (st_q)
      S_OFF:   if (start)    nxt = S_RST;
      S_RST:   if (tmr_done) nxt = S_CKE;
      S_CKE:   if (tmr_done) nxt = S_MRS;
      S_MRS:                 nxt = S_MRSW;
      S_MRSW:  if (tmr_done) nxt = last_mr ? S_ZQL : S_MRS;
      S_ZQL:                 nxt = S_ZQLW;
      S_ZQLW:  if (tmr_done) nxt = boot_q ? S_DLL : disp;
      S_DLL:   if (tmr_done) nxt = disp;
      S_IDLE:                nxt = disp;
      S_ZQS:                 nxt = S_ZQSW;
      S_ZQSW:  if (tmr_done) nxt = disp;
      default:               nxt = S_OFF;
    endcase
  end

  // timer reload on every state change: cycles spent in the next state minus one
  always_comb begin
    tmr_load = (nxt != st_q);
    unique case (nxt)
      S_RST:   ld_val = CNT_W'(T_RST - 1);
      S_CKE:   ld_val = CNT_W'(T_CKE - 1);
      S_MRSW:  ld_val = last_mr ? CNT_W'(T_MOD - 2) : CNT_W'(T_MRD - 2);
      S_ZQLW:  ld_val = boot_q ? CNT_W'(T_ZQINIT - 2) : CNT_W'(T_ZQOPER - 2);
      S_DLL:   ld_val = CNT_W'(T_DLLK - 1);
      S_ZQSW:  ld_val = CNT_W'(T_ZQCS - 2);
      default: ld_val = '0;
    endcase
  end

  always_comb begin
    step_d     = (st_q == S_MRSW && tmr_done && !last_mr) ? step_q + 3'd1 : step_q;
    boot_d     = boot_q & ~(st_q == S_DLL && tmr_done);
    zqs_pend_d = zqs_any & (nxt != S_ZQS);
    srx_pend_d = srx_any & ~(nxt == S_ZQL && st_q != S_MRSW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_OFF;
      step_q     <= '0;
      boot_q     <= 1'b1;
      zqs_pend_q <= 1'b0;
      srx_pend_q <= 1'b0;
    end else begin
      st_q       <= nxt;
      step_q     <= step_d;
      boot_q     <= boot_d;
      zqs_pend_q <= zqs_pend_d;
      srx_pend_q <= srx_pend_d;
    end
  end

  // output decode
  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    bank = '0;
    unique case (st_q)
      S_MRS: begin
        cmd  = CMD_MRS;
        addr = mr_word;
        bank = BANK_W'(mr_id);
      end
      S_ZQL: begin
        cmd  = CMD_ZQL;
        addr = ADDR_W'(1) << ZQ_LONG_BIT;
      end
      S_ZQS:   cmd = CMD_ZQS;
      default: cmd = CMD_NOP;
    endcase
  end

  assign dram_reset_n = (st_q != S_OFF) && (st_q != S_RST);
  assign cke          = dram_reset_n && (st_q != S_CKE);
  assign ready        = (st_q == S_IDLE);
  assign busy         = ~ready;

endmodule

// File: rtl/dzq_seq_chk.sv
module dzq_seq_chk
  import dzq_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BANK_W   = 3,
  parameter int T_MRD    = 8,
  parameter int T_MOD    = 24,
  parameter int T_ZQOPER = 256,
  parameter int T_ZQCS   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dram_reset_n,
  input logic              cke,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              busy,
  input logic              ready
);

  localparam int MIN_MR = (T_MRD < T_MOD) ? T_MRD : T_MOD;

  logic              mr_seen_q, cmd_seen_q;
  logic [BANK_W-1:0] last_bank_q, succ;
  logic [31:0]       gap_q, need_q;

  always_comb begin
    unique case (last_bank_q)
      BANK_W'(3): succ = BANK_W'(6);
      BANK_W'(6): succ = BANK_W'(5);
      BANK_W'(5): succ = BANK_W'(4);
      BANK_W'(4): succ = BANK_W'(2);
      BANK_W'(2): succ = BANK_W'(1);
      default:    succ = BANK_W'(0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_seen_q   <= 1'b0;
      cmd_seen_q  <= 1'b0;
      last_bank_q <= '0;
      gap_q       <= '0;
      need_q      <= '0;
    end else begin
      if (cmd == CMD_MRS) begin
        mr_seen_q   <= 1'b1;
        last_bank_q <= bank;
      end
      if (cmd != CMD_NOP) begin
        cmd_seen_q <= 1'b1;
        gap_q      <= 32'd1;
        unique case (cmd)
          CMD_MRS: need_q <= 32'(MIN_MR);
          CMD_ZQL: need_q <= 32'(T_ZQOPER);
          default: need_q <= 32'(T_ZQCS);
        endcase
      end else if (gap_q != 32'hFFFF_FFFF) begin
        gap_q <= gap_q + 32'd1;
      end
    end
  end

  // R2
  cke_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> dram_reset_n);

  // R2
  reset_release_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_reset_n) |-> !cke);

  // R3
  mr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS && !mr_seen_q) |-> bank == BANK_W'(3));

  // R3
  mr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS && mr_seen_q) |-> bank == succ);

  // R5
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == CMD_NOP && cke && addr == '0));

  // R6
  zqs_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ZQS) |=> busy);

  // R7
  zql_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ZQL) |=> busy);

  // R8
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP && cmd_seen_q) |-> gap_q >= need_q);

endmodule

bind dram_init_zq_seq dzq_seq_chk #(
  .ADDR_W   (ADDR_W),
  .BANK_W   (BANK_W),
  .T_MRD    (T_MRD),
  .T_MOD    (T_MOD),
  .T_ZQOPER (T_ZQOPER),
  .T_ZQCS   (T_ZQCS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dram_reset_n (dram_reset_n),
  .cke          (cke),
  .cmd          (cmd),
  .addr         (addr),
  .bank         (bank),
  .busy         (busy),
  .ready        (ready)
);

// File: tb/dram_init_zq_seq_tb.sv
`timescale 1ns/1ps
module dram_init_zq_seq_tb;

  localparam int AW = 14, BW = 3, ZQB = 10;
  localparam int RST = 4, CKE = 3, MRD = 4, MOD = 5;
  localparam int ZQI = 20, ZQO = 12, ZQS = 6, DLLK = 7;
  localparam int M0 = RST + CKE;
  localparam int ZC = M0 + 6*MRD + MOD;
  localparam int RDY = ZC + ZQI + DLLK;
  localparam int NOP = 0, MRS = 1, ZQL = 2, ZQC = 3;
  localparam int ORD [7] = '{3, 6, 5, 4, 2, 1, 0};

  logic clk = 1'b0;
  logic rst_n, start, zqcs_req, sr_exit;
  logic [7*AW-1:0] mr_values;
  logic dram_reset_n, cke, busy, ready;
  logic [1:0] cmd;
  logic [AW-1:0] addr;
  logic [BW-1:0] bank;

  int nvec = 0, nfail = 0;

  always #10 clk = ~clk;

  dram_init_zq_seq #(
    .ADDR_W(AW), .BANK_W(BW), .ZQ_LONG_BIT(ZQB),
    .T_RST(RST), .T_CKE(CKE), .T_MRD(MRD), .T_MOD(MOD),
    .T_ZQINIT(ZQI), .T_ZQOPER(ZQO), .T_ZQCS(ZQS), .T_DLLK(DLLK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .zqcs_req(zqcs_req),
    .sr_exit(sr_exit), .mr_values(mr_values), .dram_reset_n(dram_reset_n),
    .cke(cke), .cmd(cmd), .addr(addr), .bank(bank), .busy(busy), .ready(ready)
  );

  function automatic int mrv(input int n);
    return (n * 'h2C5 + 'h13) & 'h3FFF;
  endfunction

  function automatic int zqaddr();
    return 1 << ZQB;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_rst, input int e_cke, input int e_cmd,
                         input int e_addr, input int e_bank, input int e_rdy);
    chk(tag, "dram_reset_n", int'(dram_reset_n), e_rst);
    chk(tag, "cke", int'(cke), e_cke);
    chk(tag, "cmd", int'(cmd), e_cmd);
    chk(tag, "addr", int'(addr), e_addr);
    chk(tag, "bank", int'(bank), e_bank);
    chk(tag, "ready", int'(ready), e_rdy);
    chk(tag, "busy", int'(busy), 1 - e_rdy);
  endtask

  // power-up; zq_at >= 0 pulses zqcs_req in that cycle (R8)
  task automatic run_init(input int zq_at);
    int rdy_at, last;
    rdy_at = RDY + ((zq_at >= 0) ? ZQS : 0);
    last = rdy_at + 3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < last; k++) begin
      int e_cmd, e_addr, e_bank;
      string tag;
      e_cmd = NOP; e_addr = 0; e_bank = 0; tag = "R10";
      for (int i = 0; i < 7; i++)
        if (k == M0 + i*MRD) begin
          e_cmd = MRS; e_bank = ORD[i]; e_addr = mrv(ORD[i]); tag = "R3";
        end
      if (k == ZC) begin e_cmd = ZQL; e_addr = zqaddr(); tag = "R4"; end
      if (zq_at >= 0 && k == RDY) begin e_cmd = ZQC; tag = "R8"; end
      if (k < M0) tag = "R2";
      if (k >= RDY - 1 && k <= RDY + 1 && tag == "R10") tag = "R5";
      chk_all(tag, (k >= RST) ? 1 : 0, (k >= M0) ? 1 : 0, e_cmd, e_addr, e_bank,
              (k >= rdy_at) ? 1 : 0);
      zqcs_req = (k == zq_at);
      @(negedge clk);
    end
    zqcs_req = 1'b0;
  endtask

  task automatic kick(input logic zq, input logic sx);
    @(negedge clk); zqcs_req = zq; sr_exit = sx;
    @(negedge clk); zqcs_req = 1'b0; sr_exit = 1'b0;
  endtask

  task automatic watch(input string tag, input int ncyc, input int t1, input int c1,
                       input int t2, input int c2, input int rdy_at, input int pulse_at);
    for (int k = 0; k < ncyc; k++) begin
      int e_cmd;
      e_cmd = (k == t1) ? c1 : ((k == t2) ? c2 : NOP);
      chk_all(tag, 1, 1, e_cmd, (e_cmd == ZQL) ? zqaddr() : 0, 0, (k >= rdy_at) ? 1 : 0);
      zqcs_req = (k == pulse_at);
      @(negedge clk);
    end
    zqcs_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; zqcs_req = 1'b0; sr_exit = 1'b0;
    for (int n = 0; n < 7; n++) mr_values[n*AW +: AW] = AW'(mrv(n));
    repeat (3) @(negedge clk);
    chk_all("R1", 0, 0, NOP, 0, 0, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_all("R1", 0, 0, NOP, 0, 0, 0);
    end

    run_init(-1);

    kick(1'b1, 1'b0);
    watch("R6", ZQS + 3, 0, ZQC, -1, NOP, ZQS, -1);

    kick(1'b0, 1'b1);
    watch("R7", ZQO + 3, 0, ZQL, -1, NOP, ZQO, -1);

    kick(1'b1, 1'b0);
    watch("R8", 2*ZQS + 3, 0, ZQC, ZQS, ZQC, 2*ZQS, 3);

    kick(1'b1, 1'b1);
    watch("R9", ZQO + ZQS + 3, 0, ZQL, ZQO, ZQC, ZQO + ZQS, -1);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    watch("R11", 6, -1, NOP, -1, NOP, 0, -1);

    kick(1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_all("R1", 0, 0, NOP, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_all("R1", 0, 0, NOP, 0, 0, 0);
    end

    run_init(2);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule